// File: doc/BRIEF.md
# Radix-4 Delay-Feedback FFT Pipeline Stage

This block is one stage of a streaming radix-4 decimation-in-frequency FFT/IFFT pipeline. It accepts one complex sample per clock when `inValid` is high and produces one complex sample per accepted input once it has filled. A block of `4*FIFO_LEN` samples is processed in four equal phases. During the first three phases each arriving sample is parked in one of three register FIFOs. During the last phase the arriving sample meets the three FIFO heads in a radix-4 butterfly. That butterfly uses only adders, real/imaginary swaps and negation.

The first butterfly result leaves the stage at once. The other three are written back into the FIFOs that were just read. They are drained while the next block fills those FIFOs. Every result is divided by four with an arithmetic right shift, so the stage cannot overflow. The `inverse` input selects the sign of the ±j rotations and so chooses between forward and inverse transform. Twiddle multiplication is left to whatever follows the stage. Several stages with `FIFO_LEN` of 16, 4 and 1, with twiddles between them, form a 64-point transform.

Top module: `r4sdf_stage`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outRe`/`outIm` are 0. The phase counter starts in phase 0 after reset.
- R2: For the first `3*FIFO_LEN` accepted samples after reset, `outValid` stays 0.
- R3: Name the four samples of a block at offset i x0=x(i), x1=x(i+L), x2=x(i+2L), x3=x(i+3L), with L=`FIFO_LEN`. The clock after x3 is accepted, the stage outputs y0(i) = (x0+x1+x2+x3) >>> 2.
- R4: After the L values of y0, the stage outputs y1(0..L-1), then y2(0..L-1), then y3(0..L-1). Each comes one clock after one of the first `3L` samples of the next block is accepted.
- R5: With `inverse`=0: y1 = (x0 − j·x1 − x2 + j·x3)>>>2, y2 = (x0 − x1 + x2 − x3)>>>2 and y3 = (x0 + j·x1 − x2 − j·x3)>>>2. Here j·(a+jb) = −b+ja.
- R6: With `inverse`=1 (sampled during the last phase), the signs of all j terms in R5 are flipped. y0 and y2 are unchanged.
- R7: A clock with `inValid`=0 produces `outValid`=0 on the next clock. It leaves `outRe`/`outIm` and the phase position unchanged, and accepted samples keep their order across such gaps.
- R8: After priming, every accepted sample yields exactly one output with `outValid`=1, one clock later.
- R9: Full-scale inputs (−2^(DATA_W−1) and 2^(DATA_W−1)−1) produce exact results with no wrap-around.
- R10: The divide by four rounds toward minus infinity: a sum of −1 gives −1, not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample present this clock |
| inverse | input | 1 | 1 selects inverse transform rotations |
| inRe | input | DATA_W | Input real part, two's complement |
| inIm | input | DATA_W | Input imaginary part, two's complement |
| outValid | output | 1 | Output sample present |
| outRe | output | DATA_W | Output real part |
| outIm | output | DATA_W | Output imaginary part |

## Verification
In the last phase the stage does two things in one clock. It emits y0 for the current block and writes y1..y3 back into the FIFOs whose previous heads fed the butterfly. In the three earlier phases it also does two things in one clock: it drains one old result and stores one new sample in the same FIFO. The bench sends blocks back to back, some with idle gaps inserted, so every FIFO is pushed and popped in the same clock while the previous block is still inside. A scoreboard holds integer DFT-by-4 values, queued in the order of R4. Any result lost or overwritten by the simultaneous push shows up as a mismatch in a later block.

// File: rtl/r4sdf_pkg.sv
package r4sdf_pkg;

  // Strobes from the phase controller to the datapath
  typedef struct packed {
    logic       adv;        // a sample is accepted this clock
    logic [2:0] shiftEn;    // per-FIFO shift enable
    logic       bflyPhase;  // last phase: butterfly active
    logic [1:0] mode;       // current phase 0..3
    logic       emit;       // the result register carries a valid output
  } stageCtl_t;

endpackage

// File: rtl/r4sdf_fifo.sv
module r4sdf_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     shiftEn,
  input  logic signed [DATA_W-1:0] dinRe,
  input  logic signed [DATA_W-1:0] dinIm,
  output logic signed [DATA_W-1:0] headRe,
  output logic signed [DATA_W-1:0] headIm
);

  logic signed [DATA_W-1:0] memRe [DEPTH];
  logic signed [DATA_W-1:0] memIm [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memRe[i] <= '0;
        memIm[i] <= '0;
      end
    end else if (shiftEn) begin
      memRe[0] <= dinRe;
      memIm[0] <= dinIm;
      for (int i = 1; i < DEPTH; i++) begin
        memRe[i] <= memRe[i-1];
        memIm[i] <= memIm[i-1];
      end
    end
  end

  assign headRe = memRe[DEPTH-1];
  assign headIm = memIm[DEPTH-1];

endmodule

// File: rtl/r4sdf_bfly.sv
module r4sdf_bfly #(
  parameter int DATA_W = 16
) (
  input  logic                   inverse,
  input  logic [3:0][DATA_W-1:0] xRe,
  input  logic [3:0][DATA_W-1:0] xIm,
  output logic [3:0][DATA_W-1:0] yRe,
  output logic [3:0][DATA_W-1:0] yIm
);

  localparam int EW = DATA_W + 2;

  logic signed [EW-1:0] eRe [4];
  logic signed [EW-1:0] eIm [4];
  logic signed [EW-1:0] fullRe [4];
  logic signed [EW-1:0] fullIm [4];

  for (genvar n = 0; n < 4; n++) begin : g_ext
    assign eRe[n] = {{2{xRe[n][DATA_W-1]}}, xRe[n]};
    assign eIm[n] = {{2{xIm[n][DATA_W-1]}}, xIm[n]};
  end

  logic signed [EW-1:0] sAcRe, sAcIm, sBdRe, sBdIm;
  logic signed [EW-1:0] dAcRe, dAcIm, dBdRe, dBdIm;
  logic signed [EW-1:0] vRe, vIm, upRe, upIm, dnRe, dnIm;

  always_comb begin
    sAcRe = eRe[0] + eRe[2];
    sAcIm = eIm[0] + eIm[2];
    sBdRe = eRe[1] + eRe[3];
    sBdIm = eIm[1] + eIm[3];
    dAcRe = eRe[0] - eRe[2];
    dAcIm = eIm[0] - eIm[2];
    dBdRe = eRe[1] - eRe[3];
    dBdIm = eIm[1] - eIm[3];
    // j*(x1-x3): swap parts, negate the new real part
    vRe   = -dBdIm;
    vIm   = dBdRe;
    upRe  = dAcRe + vRe;
    upIm  = dAcIm + vIm;
    dnRe  = dAcRe - vRe;
    dnIm  = dAcIm - vIm;

    fullRe[0] = sAcRe + sBdRe;
    fullIm[0] = sAcIm + sBdIm;
    fullRe[2] = sAcRe - sBdRe;
    fullIm[2] = sAcIm - sBdIm;
    fullRe[1] = inverse ? upRe : dnRe;
    fullIm[1] = inverse ? upIm : dnIm;
    fullRe[3] = inverse ? dnRe : upRe;
    fullIm[3] = inverse ? dnIm : upIm;

    for (int k = 0; k < 4; k++) begin
      yRe[k] = fullRe[k][EW-1:2];
      yIm[k] = fullIm[k][EW-1:2];
    end
  end

endmodule

// File: rtl/r4sdf_ctrl.sv
module r4sdf_ctrl
  import r4sdf_pkg::*;
#(
  parameter int FIFO_LEN = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      primed
);

  localparam int PW = $clog2(4 * FIFO_LEN);

  logic [PW-1:0] pos;
  logic [1:0]    mode;

  assign mode = pos[PW-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos    <= '0;
      primed <= 1'b0;
    end else if (inValid) begin
      pos <= pos + 1'b1;
      if (pos == {PW{1'b1}}) primed <= 1'b1;
    end
  end

  always_comb begin
    ctl.adv       = inValid;
    ctl.mode      = mode;
    ctl.bflyPhase = (mode == 2'd3);
    ctl.emit      = inValid && (primed || mode == 2'd3);
    for (int k = 0; k < 3; k++)
      ctl.shiftEn[k] = inValid && (mode == 2'(k) || mode == 2'd3);
  end

endmodule

// File: rtl/r4sdf_datapath.sv
module r4sdf_datapath
  import r4sdf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FIFO_LEN = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageCtl_t                ctl,
  input  logic                     inverse,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);

  logic [2:0][DATA_W-1:0] headRe, headIm;
  logic [3:0][DATA_W-1:0] xRe, xIm, yRe, yIm;

  for (genvar k = 0; k < 3; k++) begin : g_fifo
    logic signed [DATA_W-1:0] dRe, dIm;
    assign dRe = ctl.bflyPhase ? yRe[k+1] : inRe;
    assign dIm = ctl.bflyPhase ? yIm[k+1] : inIm;
    r4sdf_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_LEN)) u_fifo (
      .clk    (clk),
      .rstN   (rstN),
      .shiftEn(ctl.shiftEn[k]),
      .dinRe  (dRe),
      .dinIm  (dIm),
      .headRe (headRe[k]),
      .headIm (headIm[k])
    );
  end

  assign xRe = {inRe, headRe[2], headRe[1], headRe[0]};
  assign xIm = {inIm, headIm[2], headIm[1], headIm[0]};

  r4sdf_bfly #(.DATA_W(DATA_W)) u_bfly (
    .inverse(inverse),
    .xRe    (xRe),
    .xIm    (xIm),
    .yRe    (yRe),
    .yIm    (yIm)
  );

  logic signed [DATA_W-1:0] selRe, selIm;

  always_comb begin
    case (ctl.mode)
      2'd0:    begin selRe = headRe[0]; selIm = headIm[0]; end
      2'd1:    begin selRe = headRe[1]; selIm = headIm[1]; end
      2'd2:    begin selRe = headRe[2]; selIm = headIm[2]; end
      default: begin selRe = yRe[0];    selIm = yIm[0];    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else if (ctl.adv) begin
      outValid <= ctl.emit;
      outRe    <= selRe;
      outIm    <= selIm;
    end else begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/r4sdf_stage.sv
module r4sdf_stage
  import r4sdf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FIFO_LEN = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inverse,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);

  stageCtl_t  ctl;
  logic       primed;
  logic [1:0] curMode;

  assign curMode = ctl.mode;

  r4sdf_ctrl #(.FIFO_LEN(FIFO_LEN)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .ctl    (ctl),
    .primed (primed)
  );

  r4sdf_datapath #(.DATA_W(DATA_W), .FIFO_LEN(FIFO_LEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inverse (inverse),
    .inRe    (inRe),
    .inIm    (inIm),
    .outValid(outValid),
    .outRe   (outRe),
    .outIm   (outIm)
  );

endmodule

// File: rtl/r4sdf_stage_chk.sv
module r4sdf_stage_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        curMode,
  input logic              primed,
  input logic              outValid,
  input logic [DATA_W-1:0] outRe,
  input logic [DATA_W-1:0] outIm
);

  AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                        // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outRe) && $stable(outIm)));               // R7
  AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(curMode));                                 // R7
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !primed && curMode != 2'd3) |=> !outValid);         // R2
  AST_Y0_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && curMode == 2'd3) |=> outValid);                     // R3
  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));                                   // R8

endmodule

bind r4sdf_stage r4sdf_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .curMode (curMode),
  .primed  (primed),
  .outValid(outValid),
  .outRe   (outRe),
  .outIm   (outIm)
);

// File: tb/r4sdf_stage_bench.sv
module r4sdf_stage_bench;

  localparam int DW  = 16;
  localparam int L   = 4;
  localparam int BLK = 4 * L;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inverse = 1'b0;
  logic signed [DW-1:0] inRe = '0;
  logic signed [DW-1:0] inIm = '0;
  logic                 outValid;
  logic signed [DW-1:0] outRe, outIm;

  r4sdf_stage #(.DATA_W(DW), .FIFO_LEN(L)) u_r4sdf_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inverse(inverse),
    .inRe(inRe), .inIm(inIm), .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  int    qRe[$];
  int    qIm[$];
  string qTag[$];
  int    checks = 0;
  int    errors = 0;
  int    obsCount = 0;
  int    blkRe[BLK];
  int    blkIm[BLK];
  int    seed = 32'h1234_5678;
  bit    armed = 1'b0;
  bit    finished = 1'b0;
  logic  inValidQ = 1'b0;

  always @(posedge clk) inValidQ <= rstN ? inValid : 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 12) & 32'hFFFF) - 32768;
  endfunction

  // multiply (re,im) by j^q
  function automatic void rotJ(input int re, input int im, input int q,
                               output int oRe, output int oIm);
    case (q % 4)
      0: begin oRe = re;  oIm = im;  end
      1: begin oRe = -im; oIm = re;  end
      2: begin oRe = -re; oIm = -im; end
      default: begin oRe = im; oIm = -re; end
    endcase
  endfunction

  // 4-point DFT term k at offset i, divided by 4 rounding down
  task automatic pushExp(input int i, input int k, input bit inv, input string tag);
    int sRe = 0, sIm = 0, tRe, tIm, q;
    for (int n = 0; n < 4; n++) begin
      q = inv ? (n * k) : (3 * n * k);
      rotJ(blkRe[i + n*L], blkIm[i + n*L], q, tRe, tIm);
      sRe += tRe;
      sIm += tIm;
    end
    qRe.push_back(sRe >>> 2);
    qIm.push_back(sIm >>> 2);
    qTag.push_back(tag);
  endtask

  task automatic sendBlock(input int stallEvery, input bit inv, input bit first,
                           input string y0Tag, input string ykTag);
    for (int p = 0; p < BLK; p++) begin
      if (stallEvery > 0 && (p % stallEvery) == 1) begin
        @(negedge clk);
        inValid = 1'b0;
      end
      @(negedge clk);
      if (first && p == 3*L) check("R2", "outValid before first butterfly", int'(outValid), 0);
      if (p >= 3*L) pushExp(p - 3*L, 0, inv, y0Tag);
      inValid = 1'b1;
      inverse = inv;
      inRe    = DW'(blkRe[p]);
      inIm    = DW'(blkIm[p]);
    end
    for (int k = 1; k < 4; k++)
      for (int i = 0; i < L; i++) pushExp(i, k, inv, ykTag);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (armed) begin
      if (!inValidQ) begin
        check("R7", "outValid after idle clock", int'(outValid), 0);
      end else if (outValid) begin
        obsCount++;
        if (qRe.size() == 0) begin
          check("R2", "unexpected output (queue empty)", 1, 0);
        end else begin
          automatic string t = qTag.pop_front();
          automatic int eRe = qRe.pop_front();
          automatic int eIm = qIm.pop_front();
          check(t, "outRe", int'(outRe), eRe);
          check(t, "outIm", int'(outIm), eIm);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL WATCHDOG: run hung actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "outRe in reset", int'(outRe), 0);
    check("R1", "outIm in reset", int'(outIm), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    armed = 1'b1;

    // block 0: ramp, forward, back to back
    for (int p = 0; p < BLK; p++) begin blkRe[p] = p*100 - 700; blkIm[p] = 300 - p*37; end
    sendBlock(0, 1'b0, 1'b1, "R3", "R4");
    // block 1: pseudo-random, forward, idle gaps
    for (int p = 0; p < BLK; p++) begin blkRe[p] = nextRand(); blkIm[p] = nextRand(); end
    sendBlock(3, 1'b0, 1'b0, "R7", "R5");
    // block 2: pseudo-random, inverse
    for (int p = 0; p < BLK; p++) begin blkRe[p] = nextRand(); blkIm[p] = nextRand(); end
    sendBlock(0, 1'b1, 1'b0, "R6", "R6");
    // block 3: full-scale values
    for (int p = 0; p < BLK; p++) begin
      blkRe[p] = ((p / L) % 2 == 0) ? 32767 : -32768;
      blkIm[p] = -32768;
    end
    sendBlock(5, 1'b0, 1'b0, "R9", "R9");
    // block 4: small negatives, floor rounding
    for (int p = 0; p < BLK; p++) begin
      blkRe[p] = (p < L) ? -1 : 0;
      blkIm[p] = (p < L) ? -3 : ((p % 2 == 0) ? 1 : 0);
    end
    sendBlock(0, 1'b1, 1'b0, "R10", "R10");
    // block 5: zeros to flush previous results
    for (int p = 0; p < BLK; p++) begin blkRe[p] = 0; blkIm[p] = 0; end
    sendBlock(0, 1'b0, 1'b0, "R3", "R4");

    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", "outputs observed", obsCount, 6*BLK - 3*L);
    check("R8", "results left in flight", qRe.size(), 3*L);
    finishRun();
  end

endmodule